// File: doc/BRIEF.md
# Value-Deduplicating Cache Data Store

This block is the data array of a small cache in which each distinct wide data word is held exactly once. Every cache line keeps a short pointer record instead of a word. The record has a valid bit, an inline flag and a field. The field either indexes a shared value table or, for words that fit in a few signed bits, holds the word itself. Value-table slots carry reference counts. A write looks for its word among the live slots. On a match it shares that slot and raises its count. Otherwise it claims a free slot. When a line is overwritten or evicted, the count of the slot it held drops by one. A slot whose count reaches zero becomes free again.

A write is a fixed three-state sequence in a controller. In `ST_IDLE` a request on `wr_en` is latched (transition *accept*) and the controller moves to `ST_COMPARE`. In that state the associative lookup and the free-slot search are registered (transition *lookup done*), and the controller moves to `ST_COMMIT`. In `ST_COMMIT` the line and the table are updated, or the write is refused, and the controller returns to `ST_IDLE` (transition *retire*). An evict is taken only in `ST_IDLE` and only when no write is requested in the same cycle. Reads are independent of the sequence and return the stored word one clock later.

Address tags, hit/miss decisions and refills belong to the surrounding cache and are not part of this block.

Top module: `dedup_cache_store`

## Requirements
- R1: After any sequence of accepted writes and evicts, a read of a valid line returns the last word accepted for it, including when several lines hold the same word.
- R2: A word whose bits from position NARROW_W-1 upward are all equal (default NARROW_W=4: -8..7) is stored inline, is sign-extended on read, and is accepted even when every value-table slot is in use.
- R3: A write of a wide word that matches no live slot while all SLOTS slots are in use is refused. `wr_stall` is high during `ST_COMMIT`, `wr_done` stays low, and no line changes. This holds even if the target line is the only holder of its old slot.
- R4: A slot whose last reference is removed, by eviction or by an overwrite, is reusable, so a later new wide word is accepted.
- R5: A write accepted in cycle t gives `wr_busy` high in cycles t+1 and t+2. In cycle t+2 exactly one of `wr_done`/`wr_stall` is high. `wr_busy` is low in t+3.
- R6: `rd_data`/`rd_hit` in cycle t+1 reflect line `rd_line` as stored at cycle t.
- R7: After an evict of a line, a read of that line gives `rd_hit`=0 and `rd_data`=0.
- R8: `wr_en` while `wr_busy` is high is ignored.
- R9: After reset every line is invalid and `rd_hit`=0, `rd_data`=0, `wr_busy`=0.
- R10: `ev_en` is ignored while `wr_busy` is high, or when `wr_en` is high in the same idle cycle.
- R11: A wide word already live in the table is accepted even when all slots are in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request, taken when idle |
| wr_line | input | $clog2(LINES) | Line to write |
| wr_data | input | DATA_W | Word to write |
| wr_busy | output | 1 | Write sequence in progress |
| wr_done | output | 1 | Write completed (in ST_COMMIT) |
| wr_stall | output | 1 | Write refused, table full (in ST_COMMIT) |
| ev_en | input | 1 | Evict request |
| ev_line | input | $clog2(LINES) | Line to evict |
| rd_line | input | $clog2(LINES) | Line to read |
| rd_hit | output | 1 | Read line was valid (registered) |
| rd_data | output | DATA_W | Read word (registered), 0 when invalid |

## Verification
The assertions assume the environment only changes the table through the ports. They assume a line's old slot and a newly matched slot may coincide. They also assume an evict and a commit never land in the same cycle, which the controller itself guarantees by gating evicts to idle. The stimulus uses a small pool of wide words so that sharing, overwrite of shared lines, and exact table-full boundaries occur often. It also deliberately raises `wr_en` and `ev_en` while busy to exercise the ignore rules. A behavioural model tracks only line contents and derives slot occupancy from the number of distinct wide words, so refusal is predicted without mirroring any slot structure.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COMPARE = 2'd1,
        ST_COMMIT  = 2'd2
    } wr_state_t;
endpackage

// File: rtl/ddc_value_table.sv
module ddc_value_table #(
    parameter int DATA_W = 32,
    parameter int SLOTS  = 8,
    parameter int LINES  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DATA_W-1:0]        cmp_data,
    output logic                     hit,
    output logic [$clog2(SLOTS)-1:0] hit_idx,
    output logic                     free_any,
    output logic [$clog2(SLOTS)-1:0] free_idx,
    input  logic [$clog2(SLOTS)-1:0] rd_idx,
    output logic [DATA_W-1:0]        rd_val,
    input  logic                     alloc_en,
    input  logic [$clog2(SLOTS)-1:0] alloc_idx,
    input  logic [DATA_W-1:0]        alloc_data,
    input  logic                     inc_en,
    input  logic [$clog2(SLOTS)-1:0] inc_idx,
    input  logic                     dec_en,
    input  logic [$clog2(SLOTS)-1:0] dec_idx
);
    localparam int IDX_W = $clog2(SLOTS);
    localparam int CNT_W = $clog2(LINES + 1);

    logic [DATA_W-1:0] val_q [SLOTS];
    logic [CNT_W-1:0]  cnt_q [SLOTS];
    logic [SLOTS-1:0]  match_vec;
    logic [SLOTS-1:0]  free_vec;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign match_vec[g] = (cnt_q[g] != '0) && (val_q[g] == cmp_data);
        assign free_vec[g]  = (cnt_q[g] == '0);
    end

    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (match_vec[i]) hit_idx  = IDX_W'(i);
            if (free_vec[i])  free_idx = IDX_W'(i);
        end
    end

    assign hit      = |match_vec;
    assign free_any = |free_vec;
    assign rd_val   = val_q[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                val_q[i] <= '0;
                cnt_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (alloc_en && alloc_idx == IDX_W'(i))
                    val_q[i] <= alloc_data;
                cnt_q[i] <= cnt_q[i]
                          + CNT_W'(inc_en && inc_idx == IDX_W'(i))
                          - CNT_W'(dec_en && dec_idx == IDX_W'(i));
            end
        end
    end

    // R1: a live word lives in at most one slot
    assert_single_copy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));
    // R4: a release never targets an unreferenced slot
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en |-> cnt_q[dec_idx] != '0);
    // R3: allocation only into a free slot
    assert_alloc_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> cnt_q[alloc_idx] == '0);
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !(dec_en && dec_idx == inc_idx)) |-> cnt_q[inc_idx] != CNT_W'(LINES));
endmodule

// File: rtl/ddc_line_array.sv
module ddc_line_array #(
    parameter int LINES   = 16,
    parameter int FIELD_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(LINES)-1:0] wr_idx,
    input  logic                     wr_inl,
    input  logic [FIELD_W-1:0]       wr_fld,
    input  logic                     clr_en,
    input  logic [$clog2(LINES)-1:0] clr_idx,
    input  logic [$clog2(LINES)-1:0] a_idx,
    output logic                     a_valid,
    output logic                     a_inl,
    output logic [FIELD_W-1:0]       a_fld,
    input  logic [$clog2(LINES)-1:0] b_idx,
    output logic                     b_valid,
    output logic                     b_inl,
    output logic [FIELD_W-1:0]       b_fld
);
    logic               valid_q [LINES];
    logic               inl_q   [LINES];
    logic [FIELD_W-1:0] fld_q   [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                valid_q[i] <= 1'b0;
                inl_q[i]   <= 1'b0;
                fld_q[i]   <= '0;
            end
        end else begin
            if (wr_en) begin
                valid_q[wr_idx] <= 1'b1;
                inl_q[wr_idx]   <= wr_inl;
                fld_q[wr_idx]   <= wr_fld;
            end
            if (clr_en)
                valid_q[clr_idx] <= 1'b0;
        end
    end

    assign a_valid = valid_q[a_idx];
    assign a_inl   = inl_q[a_idx];
    assign a_fld   = fld_q[a_idx];
    assign b_valid = valid_q[b_idx];
    assign b_inl   = inl_q[b_idx];
    assign b_fld   = fld_q[b_idx];

    // R10: a commit and an evict never update the array together
    assert_one_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && clr_en));
endmodule

// File: rtl/ddc_write_ctrl.sv
module ddc_write_ctrl
    import ddc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ok,
    output logic busy,
    output logic accept,
    output logic do_compare,
    output logic commit_ok,
    output logic done,
    output logic stall
);
    wr_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_COMPARE;
            ST_COMPARE: state_d = ST_COMMIT;
            ST_COMMIT:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy       = 1'b0;
        accept     = 1'b0;
        do_compare = 1'b0;
        commit_ok  = 1'b0;
        done       = 1'b0;
        stall      = 1'b0;
        unique case (state_q)
            ST_IDLE:    accept = start;
            ST_COMPARE: begin busy = 1'b1; do_compare = 1'b1; end
            ST_COMMIT:  begin
                busy      = 1'b1;
                commit_ok = ok;
                done      = ok;
                stall     = !ok;
            end
            default: ;
        endcase
    end

    // R5: fixed sequence
    assert_compare_then_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_COMPARE |=> state_q == ST_COMMIT);
    assert_commit_then_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_COMMIT |=> state_q == ST_IDLE);
endmodule

// File: rtl/dedup_cache_store.sv
module dedup_cache_store #(
    parameter int DATA_W   = 32,
    parameter int LINES    = 16,
    parameter int SLOTS    = 8,
    parameter int NARROW_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(LINES)-1:0] wr_line,
    input  logic [DATA_W-1:0]        wr_data,
    output logic                     wr_busy,
    output logic                     wr_done,
    output logic                     wr_stall,
    input  logic                     ev_en,
    input  logic [$clog2(LINES)-1:0] ev_line,
    input  logic [$clog2(LINES)-1:0] rd_line,
    output logic                     rd_hit,
    output logic [DATA_W-1:0]        rd_data
);
    localparam int LINE_W  = $clog2(LINES);
    localparam int IDX_W   = $clog2(SLOTS);
    localparam int FIELD_W = (NARROW_W > IDX_W) ? NARROW_W : IDX_W;
    localparam int EXT_W   = DATA_W - NARROW_W;

    // request and lookup registers
    logic [LINE_W-1:0] req_line;
    logic [DATA_W-1:0] req_data;
    logic              req_narrow;
    logic              c_hit, c_free;
    logic [IDX_W-1:0]  c_hit_idx, c_free_idx;

    logic accept, do_compare, commit_ok, ok;
    logic ev_fire;

    logic              vt_hit, vt_free;
    logic [IDX_W-1:0]  vt_hit_idx, vt_free_idx;
    logic [DATA_W-1:0] vt_rd_val;

    logic               a_valid, a_inl, b_valid, b_inl;
    logic [FIELD_W-1:0] a_fld, b_fld;
    logic [LINE_W-1:0]  a_idx;

    logic               line_we;
    logic [FIELD_W-1:0] line_fld;
    logic               dec_en, inc_en, alloc_en;
    logic [IDX_W-1:0]   use_idx;

    logic in_narrow;
    assign in_narrow = (wr_data[DATA_W-1:NARROW_W-1] == '0)
                    || (wr_data[DATA_W-1:NARROW_W-1] == '1);

    ddc_write_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(wr_en), .ok(ok),
        .busy(wr_busy), .accept(accept), .do_compare(do_compare),
        .commit_ok(commit_ok), .done(wr_done), .stall(wr_stall)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_line   <= '0;
            req_data   <= '0;
            req_narrow <= 1'b0;
            c_hit      <= 1'b0;
            c_free     <= 1'b0;
            c_hit_idx  <= '0;
            c_free_idx <= '0;
        end else begin
            if (accept) begin
                req_line   <= wr_line;
                req_data   <= wr_data;
                req_narrow <= in_narrow;
            end
            if (do_compare) begin
                c_hit      <= vt_hit;
                c_free     <= vt_free;
                c_hit_idx  <= vt_hit_idx;
                c_free_idx <= vt_free_idx;
            end
        end
    end

    assign ok       = req_narrow || c_hit || c_free;
    assign use_idx  = c_hit ? c_hit_idx : c_free_idx;
    assign line_we  = commit_ok;
    assign line_fld = req_narrow ? FIELD_W'(req_data[NARROW_W-1:0]) : FIELD_W'(use_idx);
    assign inc_en   = commit_ok && !req_narrow;
    assign alloc_en = commit_ok && !req_narrow && !c_hit;

    assign ev_fire  = !wr_busy && !wr_en && ev_en;
    assign a_idx    = wr_busy ? req_line : ev_line;
    assign dec_en   = (commit_ok || ev_fire) && a_valid && !a_inl;

    ddc_value_table #(.DATA_W(DATA_W), .SLOTS(SLOTS), .LINES(LINES)) u_table (
        .clk(clk), .rst_n(rst_n),
        .cmp_data(req_data), .hit(vt_hit), .hit_idx(vt_hit_idx),
        .free_any(vt_free), .free_idx(vt_free_idx),
        .rd_idx(IDX_W'(b_fld)), .rd_val(vt_rd_val),
        .alloc_en(alloc_en), .alloc_idx(use_idx), .alloc_data(req_data),
        .inc_en(inc_en), .inc_idx(use_idx),
        .dec_en(dec_en), .dec_idx(IDX_W'(a_fld))
    );

    ddc_line_array #(.LINES(LINES), .FIELD_W(FIELD_W)) u_lines (
        .clk(clk), .rst_n(rst_n),
        .wr_en(line_we), .wr_idx(req_line), .wr_inl(req_narrow), .wr_fld(line_fld),
        .clr_en(ev_fire), .clr_idx(ev_line),
        .a_idx(a_idx), .a_valid(a_valid), .a_inl(a_inl), .a_fld(a_fld),
        .b_idx(rd_line), .b_valid(b_valid), .b_inl(b_inl), .b_fld(b_fld)
    );

    // registered read: one cycle for inline and table-resident words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_hit  <= 1'b0;
            rd_data <= '0;
        end else begin
            rd_hit <= b_valid;
            if (!b_valid)
                rd_data <= '0;
            else if (b_inl)
                rd_data <= {{EXT_W{b_fld[NARROW_W-1]}}, b_fld[NARROW_W-1:0]};
            else
                rd_data <= vt_rd_val;
        end
    end

    // R5: busy lasts two cycles once raised
    assert_busy_two_cycles_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_busy) |=> wr_busy);
    // R3: a refused write touches no line
    assert_stall_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stall |-> !line_we && !inc_en && !dec_en);
endmodule

// File: tb/dedup_cache_store_test.sv
module dedup_cache_store_test;
    localparam int LINES = 16;
    localparam int SLOTS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_line = '0;
    logic [31:0] wr_data = '0;
    logic        ev_en = 1'b0;
    logic [3:0]  ev_line = '0;
    logic [3:0]  rd_line = '0;
    logic        wr_busy, wr_done, wr_stall, rd_hit;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dedup_cache_store #(.DATA_W(32), .LINES(LINES), .SLOTS(SLOTS), .NARROW_W(4)) uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_line(wr_line), .wr_data(wr_data),
        .wr_busy(wr_busy), .wr_done(wr_done), .wr_stall(wr_stall),
        .ev_en(ev_en), .ev_line(ev_line),
        .rd_line(rd_line), .rd_hit(rd_hit), .rd_data(rd_data)
    );

    // behavioural model: line contents only
    logic        m_valid [LINES];
    logic [31:0] m_val   [LINES];
    int          ph = 0;
    logic [3:0]  p_line;
    logic [31:0] p_data;
    logic        p_ok;
    logic        last_stall;

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    function automatic bit is_narrow(input logic [31:0] d);
        return (d[31:3] == '0) || (d[31:3] == '1);
    endfunction

    function automatic bit pred_ok(input logic [31:0] d);
        int  distinct = 0;
        bit  present = 0;
        if (is_narrow(d)) return 1;
        for (int i = 0; i < LINES; i++) begin
            if (m_valid[i] && !is_narrow(m_val[i])) begin
                bit seen = 0;
                if (m_val[i] == d) present = 1;
                for (int j = 0; j < i; j++)
                    if (m_valid[j] && m_val[j] == m_val[i]) seen = 1;
                if (!seen) distinct++;
            end
        end
        return present || (distinct < SLOTS);
    endfunction

    // one clock: checks control outputs now, read outputs after the edge
    task automatic step();
        logic        eh;
        logic [31:0] ed;
        eh = m_valid[rd_line];
        ed = eh ? m_val[rd_line] : 32'h0;
        check(32'(wr_busy), 32'(ph != 0), "R5 busy");
        check(32'(wr_done), 32'(ph == 2 && p_ok), "R5 done");
        check(32'(wr_stall), 32'(ph == 2 && !p_ok), "R3 stall");
        if (ph == 2) last_stall = wr_stall;
        @(posedge clk);
        case (ph)
            0: if (wr_en) begin
                   p_line = wr_line; p_data = wr_data; ph = 1;
               end else if (ev_en) begin
                   m_valid[ev_line] = 1'b0;
               end
            1: begin p_ok = pred_ok(p_data); ph = 2; end
            default: begin
                if (p_ok) begin m_valid[p_line] = 1'b1; m_val[p_line] = p_data; end
                ph = 0;
            end
        endcase
        @(negedge clk);
        check(32'(rd_hit), 32'(eh), "R7 rd_hit");
        check(rd_data, ed, "R1/R6 rd_data");
    endtask

    task automatic do_write(input logic [3:0] l, input logic [31:0] d);
        wr_en = 1'b1; wr_line = l; wr_data = d;
        step();
        wr_en = 1'b0;
        step();
        step();
    endtask

    task automatic do_evict(input logic [3:0] l);
        ev_en = 1'b1; ev_line = l;
        step();
        ev_en = 1'b0;
    endtask

    task automatic sweep();
        for (int i = 0; i < LINES; i++) begin
            rd_line = 4'(i);
            step();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] pool [12];
        logic [15:0] lfsr = 16'hACE1;
        for (int i = 0; i < LINES; i++) begin m_valid[i] = 1'b0; m_val[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(32'(rd_hit), 0, "R9 rd_hit after reset");
        check(rd_data, 0, "R9 rd_data after reset");
        check(32'(wr_busy), 0, "R9 busy after reset");
        sweep();

        // R2 inline words, both boundaries
        do_write(0, 32'd5);
        do_write(1, 32'hFFFF_FFF8);
        do_write(2, 32'd7);
        // R1 shared word
        do_write(3, 32'hDEAD_BEEF);
        do_write(4, 32'hDEAD_BEEF);
        do_write(5, 32'hDEAD_BEEF);
        // just outside the inline range
        do_write(6, 32'd8);
        do_write(7, 32'hFFFF_FFF7);
        for (int k = 1; k <= 5; k++) do_write(4'(7 + k), 32'(k * 256));
        sweep();
        rd_line = 1; step(); step();
        check(rd_data, 32'hFFFF_FFF8, "R2 sign extension of -8");

        // R3 full table refuses a new word
        do_write(13, 32'h1234_5678);
        check(32'(last_stall), 1, "R3 new word with full table");
        do_write(3, 32'h1234_5678);
        check(32'(last_stall), 1, "R3 shared line not overwritten");
        do_write(6, 32'h1234_5678);
        check(32'(last_stall), 1, "R3 sole holder still refused");
        // R11 and R2 accepted while full
        do_write(13, 32'hDEAD_BEEF);
        check(32'(last_stall), 0, "R11 existing word while full");
        do_write(14, 32'hFFFF_FFFD);
        check(32'(last_stall), 0, "R2 narrow word while full");
        sweep();

        // R4 freeing by evict and by overwrite
        do_evict(6);
        do_write(15, 32'h1234_5678);
        check(32'(last_stall), 0, "R4 slot freed by evict");
        do_write(7, 32'd3);
        do_write(6, 32'hCAFE_F00D);
        check(32'(last_stall), 0, "R4 slot freed by overwrite");
        rd_line = 6; step(); step();
        check(32'(rd_hit), 1, "R4 line 6 valid");
        sweep();

        // R8 writes while busy ignored
        wr_en = 1'b1; wr_line = 0; wr_data = 32'hAAAA_0000;
        step();
        wr_line = 1; wr_data = 32'hBBBB_0000;
        step();
        step();
        wr_en = 1'b0;
        step(); step();
        rd_line = 1; step(); step();
        check(rd_data, 32'hFFFF_FFF8, "R8 busy write ignored");

        // R10 evict with write, and evict while busy
        wr_en = 1'b1; ev_en = 1'b1; wr_line = 2; wr_data = 32'd1; ev_line = 3;
        step();
        wr_en = 1'b0;
        step(); step();
        ev_en = 1'b0;
        rd_line = 3; step(); step();
        check(32'(rd_hit), 1, "R10 evict ignored");
        sweep();

        // mixed traffic from a small pool
        for (int i = 0; i < 12; i++) pool[i] = 32'h5000_0000 + 32'(i * 4099);
        pool[10] = 32'hFFFF_FFFA;
        pool[11] = 32'd2;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rd_line = lfsr[7:4];
            if (lfsr[1:0] == 2'b00) begin
                do_evict(lfsr[11:8]);
            end else if (lfsr[1:0] == 2'b01) begin
                step();
            end else begin
                do_write(lfsr[11:8], pool[32'(lfsr[15:12]) % 12]);
            end
        end
        sweep();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule